// File: doc/BRIEF.md
# Bus Master Termination Controller

This block runs the bus-master side of one burst transaction on a parallel shared bus and decides how it ended. A request arrives from the upstream queue with a start address, a command, a word count and a flag that marks a broadcast special cycle. The block drives the address phase and then the data phases. It watches the target's select, ready and stop responses and sorts each clock into one of these outcomes: word moved, disconnect, retry, target abort, master abort, or nothing yet.

Disconnects, retries and latency-timer expiry restart the burst from the word where it stopped, at the matching address. Aborts and full completion end the request. The block then returns a one-clock done pulse with a 2-bit status code and the number of words that really moved. Two sticky flags record that a master abort or a target abort was received. All bus signals at the ports are active-high: a 1 means the line is asserted. Any inversion to pin level happens outside the block.

Top module: `pci_mterm_ctrl`

## Requirements
- R1: Target select is sampled on the five clocks that follow the address clock. If it is asserted on any of them, the transaction goes on. If all five pass without it, the transaction ends with a master abort on the fifth.
- R2: A master abort on an ordinary request returns done with status 2'b01 and a count of the words moved so far, and sets sts_rx_mabort.
- R3: A special-cycle request has exactly one data phase. If it gets a master abort, it returns status 2'b00 with count 1 and leaves sts_rx_mabort unchanged.
- R4: A target abort is stop asserted while select is deasserted, after select was seen in the same transaction. It returns status 2'b10, counts only the words moved before the abort, and sets sts_rx_tabort.
- R5: Stop together with ready is a disconnect. That word counts as moved. If words remain, a new transaction starts at the next word address (4 bytes per word).
- R6: Stop without ready is a retry. No word moves. The bus stays idle for RETRY_GAP clocks (at least 2) before the same address is issued again. Retries repeat until the request ends another way.
- R7: When every requested word has moved, done returns status 2'b00 and count equal to the request length. The frame line drops on the final data phase while the ready-to-transfer line stays high.
- R8: A latency counter is loaded with LAT_INIT on the address clock and counts down on each data clock. Once it reaches zero while grant is deasserted, the current data phase is the last one, and the remaining words are issued in a new transaction.
- R9: Back-to-back transactions are never issued. At least one fully idle clock separates the end of one transaction from the next address clock.
- R10: req_ready is high only while no transaction is active. done is a single-clock pulse in the clock right after the final bus data clock, and the status code is never 2'b11.
- R11: After reset, frame and ready-to-transfer are low, req_ready is high, done is low and both sticky flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | AW | Byte address of the first word |
| req_cmd | input | 4 | Bus command for the request |
| req_len | input | LW | Word count, 1 or more |
| req_special | input | 1 | Request is a translated special cycle |
| bus_frame | output | 1 | Frame line, asserted high |
| bus_irdy | output | 1 | Master ready-to-transfer, asserted high |
| bus_addr | output | AW | Current word address (valid on the address clock) |
| bus_cmd | output | 4 | Command driven on the address clock |
| tgt_devsel | input | 1 | Target select response |
| tgt_trdy | input | 1 | Target ready |
| tgt_stop | input | 1 | Target stop request |
| bus_gnt | input | 1 | Bus grant held by this master |
| word_done | output | 1 | A data word moves on this clock |
| done | output | 1 | One-clock completion pulse |
| done_status | output | 2 | 00 normal, 01 master abort, 10 target abort |
| done_count | output | LW | Words that moved for the request |
| sts_rx_mabort | output | 1 | Sticky: master abort received |
| sts_rx_tabort | output | 1 | Sticky: target abort received |

## Verification
The target model in the bench drives select, ready and stop half a clock before the edge that samples them, so each response lands in the same data clock in which it is driven. The address is checked on the clock where frame is high and ready-to-transfer is low. Results come out on a fixed schedule. The outcome of a data clock takes effect at the next edge. done, its status and its count show one clock after the final bus data clock, and the bench checks that the clock before every done pulse had ready-to-transfer high. Idle gaps between attempts, attempt counts and expected words are computed from the request length, the select delay, the disconnect spacing and LAT_INIT, and are compared after done.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [1:0] {
    CPL_NORMAL = 2'd0,
    CPL_MABORT = 2'd1,
    CPL_TABORT = 2'd2
  } cpl_e;

  typedef enum logic [2:0] {
    OC_NONE,
    OC_XFER,
    OC_DISC,
    OC_RETRY,
    OC_TABORT,
    OC_MABORT
  } outcome_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_TURN,
    PH_BACKOFF
  } phase_e;
endpackage

// File: rtl/pmt_select_watch.sv
module pmt_select_watch #(
  parameter int WIN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_data,
  input  logic devsel_i,
  output logic seen,
  output logic window_end
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt;

  assign window_end = (cnt == CW'(WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (in_data) begin
      if (!window_end) cnt <= cnt + CW'(1);
      if (devsel_i) seen <= 1'b1;
    end
  end
endmodule

// File: rtl/pmt_lat_timer.sv
module pmt_lat_timer #(
  parameter int W = 8,
  parameter int INIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_data,
  output logic expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= W'(INIT);
    else if (in_data && !expired) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/pmt_outcome.sv
module pmt_outcome
  import pmt_pkg::*;
(
  input  logic     in_data,
  input  logic     devsel_i,
  input  logic     trdy_i,
  input  logic     stop_i,
  input  logic     seen,
  input  logic     window_end,
  output outcome_e outc
);
  always_comb begin
    outc = OC_NONE;
    if (in_data) begin
      if (seen || devsel_i) begin
        if (stop_i && !devsel_i && seen)      outc = OC_TABORT;
        else if (stop_i && devsel_i && trdy_i) outc = OC_DISC;
        else if (stop_i && devsel_i)           outc = OC_RETRY;
        else if (trdy_i && devsel_i)           outc = OC_XFER;
      end else if (window_end) begin
        outc = OC_MABORT;
      end
    end
  end
endmodule

// File: rtl/pci_mterm_ctrl.sv
module pci_mterm_ctrl
  import pmt_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 8,
  parameter int LAT_W     = 8,
  parameter int LAT_INIT  = 16,
  parameter int DSEL_WIN  = 5,
  parameter int RETRY_GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_cmd,
  input  logic [LW-1:0] req_len,
  input  logic          req_special,
  output logic          bus_frame,
  output logic          bus_irdy,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_cmd,
  input  logic          tgt_devsel,
  input  logic          tgt_trdy,
  input  logic          tgt_stop,
  input  logic          bus_gnt,
  output logic          word_done,
  output logic          done,
  output logic [1:0]    done_status,
  output logic [LW-1:0] done_count,
  output logic          sts_rx_mabort,
  output logic          sts_rx_tabort
);
  localparam int GW = $clog2(RETRY_GAP + 1);

  function automatic logic [AW-1:0] next_word_addr(input logic [AW-1:0] a);
    return a + AW'(4);
  endfunction

  function automatic logic [LW-1:0] bump(input logic [LW-1:0] c);
    return c + LW'(1);
  endfunction

  phase_e        phase;
  logic [AW-1:0] cur_addr;
  logic [3:0]    cmd_q;
  logic [LW-1:0] rem_q;
  logic [LW-1:0] moved_q;
  logic          special_q;
  logic          last_q;
  logic [GW-1:0] gap_q;

  logic     in_data, start, dsel_seen, win_end, lat_zero, last_phase, final_word;
  outcome_e outc;

  assign in_data    = (phase == PH_DATA);
  assign start      = (phase == PH_ADDR);
  assign last_phase = in_data &&
                      (last_q || special_q || rem_q == LW'(1) || (lat_zero && !bus_gnt));
  assign final_word = special_q || rem_q == LW'(1);

  assign req_ready = (phase == PH_IDLE);
  assign bus_frame = start || (in_data && !last_phase);
  assign bus_irdy  = in_data;
  assign bus_addr  = cur_addr;
  assign bus_cmd   = cmd_q;
  assign word_done = (outc == OC_XFER) || (outc == OC_DISC);

  pmt_select_watch #(.WIN(DSEL_WIN)) u_sel (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
    .devsel_i(tgt_devsel), .seen(dsel_seen), .window_end(win_end)
  );

  pmt_lat_timer #(.W(LAT_W), .INIT(LAT_INIT)) u_lat (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data), .expired(lat_zero)
  );

  pmt_outcome u_oc (
    .in_data(in_data), .devsel_i(tgt_devsel), .trdy_i(tgt_trdy), .stop_i(tgt_stop),
    .seen(dsel_seen), .window_end(win_end), .outc(outc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_IDLE;
      cur_addr      <= '0;
      cmd_q         <= '0;
      rem_q         <= '0;
      moved_q       <= '0;
      special_q     <= 1'b0;
      last_q        <= 1'b0;
      gap_q         <= '0;
      done          <= 1'b0;
      done_status   <= CPL_NORMAL;
      done_count    <= '0;
      sts_rx_mabort <= 1'b0;
      sts_rx_tabort <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            cur_addr  <= req_addr;
            cmd_q     <= req_cmd;
            rem_q     <= req_len;
            moved_q   <= '0;
            special_q <= req_special;
            phase     <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          last_q <= 1'b0;
          phase  <= PH_DATA;
        end
        PH_DATA: begin
          if (last_phase) last_q <= 1'b1;
          case (outc)
            OC_XFER, OC_DISC: begin
              moved_q  <= bump(moved_q);
              rem_q    <= rem_q - LW'(1);
              cur_addr <= next_word_addr(cur_addr);
              if (final_word) begin
                done        <= 1'b1;
                done_status <= CPL_NORMAL;
                done_count  <= bump(moved_q);
                phase       <= PH_IDLE;
              end else if (outc == OC_DISC || last_phase) begin
                phase <= PH_TURN;
              end
            end
            OC_RETRY: begin
              gap_q <= '0;
              phase <= PH_BACKOFF;
            end
            OC_TABORT: begin
              done          <= 1'b1;
              done_status   <= CPL_TABORT;
              done_count    <= moved_q;
              sts_rx_tabort <= 1'b1;
              phase         <= PH_IDLE;
            end
            OC_MABORT: begin
              done  <= 1'b1;
              phase <= PH_IDLE;
              if (special_q) begin
                done_status <= CPL_NORMAL;
                done_count  <= LW'(1);
              end else begin
                done_status   <= CPL_MABORT;
                done_count    <= moved_q;
                sts_rx_mabort <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        PH_TURN: phase <= PH_ADDR;
        PH_BACKOFF: begin
          if (gap_q == GW'(RETRY_GAP - 1)) phase <= PH_ADDR;
          else gap_q <= gap_q + GW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker
  import pmt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input outcome_e   oc,
  input logic       special,
  input logic       bus_frame,
  input logic       bus_irdy,
  input logic       req_ready,
  input logic       done,
  input logic [1:0] done_status,
  input logic       sts_rx_mabort,
  input logic       sts_rx_tabort
);
  a_r2_mabort_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (oc == OC_MABORT && !special) |=> sts_rx_mabort);

  a_r3_special_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (oc == OC_MABORT && special) |=> $stable(sts_rx_mabort));

  a_r4_tabort_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (oc == OC_TABORT) |=> sts_rx_tabort);

  a_r6_retry_backoff: assert property (@(posedge clk) disable iff (!rst_n)
    (oc == OC_RETRY) |=> !bus_frame ##1 !bus_frame);

  a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && !bus_frame && oc != OC_NONE) |=> (!bus_frame && !bus_irdy));

  a_r10_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_status != 2'b11));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_irdy && !bus_frame));
endmodule

bind pci_mterm_ctrl pmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .oc(outc), .special(special_q),
  .bus_frame(bus_frame), .bus_irdy(bus_irdy), .req_ready(req_ready),
  .done(done), .done_status(done_status),
  .sts_rx_mabort(sts_rx_mabort), .sts_rx_tabort(sts_rx_tabort)
);

// File: tb/tb_pci_mterm_ctrl.sv
module tb_pci_mterm_ctrl;
  localparam int LAT = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_special = 1'b0;
  logic [31:0] req_addr = '0, bus_addr;
  logic [3:0]  req_cmd = '0, bus_cmd;
  logic [7:0]  req_len = '0, done_count;
  logic        bus_frame, bus_irdy, bus_gnt = 1'b1;
  logic        tgt_devsel, tgt_trdy, tgt_stop;
  logic        word_done, done, sts_rx_mabort, sts_rx_tabort;
  logic [1:0]  done_status;

  pci_mterm_ctrl #(.LAT_INIT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_len(req_len), .req_special(req_special),
    .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
    .tgt_devsel(tgt_devsel), .tgt_trdy(tgt_trdy), .tgt_stop(tgt_stop), .bus_gnt(bus_gnt),
    .word_done(word_done), .done(done), .done_status(done_status), .done_count(done_count),
    .sts_rx_mabort(sts_rx_mabort), .sts_rx_tabort(sts_rx_tabort)
  );

  int checks = 0, errors = 0;
  int t_dly, t_de, t_rn, t_ta;
  int words, attempts, data_cyc, retries_done, gap_cnt, min_gap;
  int addr_bad, ready_bad, done_cnt, late_bad;
  bit ta_arm, prev_irdy;
  logic [31:0] base;
  logic [1:0]  got_st;
  logic [7:0]  got_cnt;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model and monitor, evaluated half a clock before the sampling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      tgt_devsel = 1'b0; tgt_trdy = 1'b0; tgt_stop = 1'b0;
    end else begin
      if (done) begin
        done_cnt++; got_st = done_status; got_cnt = done_count;
        if (!prev_irdy) late_bad++;
      end
      if (req_ready && (bus_irdy || bus_frame)) ready_bad++;
      if (bus_frame && !bus_irdy) begin
        attempts++;
        if (bus_addr != base + 32'(4 * words)) addr_bad++;
        if (attempts > 1 && gap_cnt < min_gap) min_gap = gap_cnt;
        gap_cnt = 0; data_cyc = 0; ta_arm = 1'b0;
      end else if (!bus_frame && !bus_irdy) begin
        gap_cnt++;
      end
      prev_irdy = bus_irdy;
      tgt_devsel = 1'b0; tgt_trdy = 1'b0; tgt_stop = 1'b0;
      if (bus_irdy) begin
        if (data_cyc >= t_dly) begin
          tgt_devsel = 1'b1;
          if (t_ta >= 0 && words == t_ta) begin
            if (!ta_arm) ta_arm = 1'b1;
            else begin tgt_devsel = 1'b0; tgt_stop = 1'b1; end
          end else if (retries_done < t_rn && data_cyc == t_dly) begin
            tgt_stop = 1'b1; retries_done++;
          end else begin
            tgt_trdy = 1'b1;
            if (t_de > 0 && ((words + 1) % t_de) == 0) tgt_stop = 1'b1;
            words++;
          end
        end
        data_cyc++;
      end
    end
  end

  task automatic run(input int len, input bit spc, input int dly, input int de, input int rn,
                     input int ta, input bit gnt, input int exp_st, input int exp_cnt,
                     input int exp_att, input int exp_gap, input string tag);
    rst_n = 1'b0;
    t_dly = dly; t_de = de; t_rn = rn; t_ta = ta;
    words = 0; attempts = 0; data_cyc = 0; retries_done = 0; gap_cnt = 0; min_gap = 1000;
    addr_bad = 0; ready_bad = 0; done_cnt = 0; late_bad = 0; ta_arm = 1'b0; prev_irdy = 1'b0;
    got_st = 2'b11; got_cnt = '0;
    base = 32'h1000_0000 + 32'(len * 256);
    bus_gnt = gnt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req_addr = base; req_len = 8'(len); req_special = spc;
    req_cmd = spc ? 4'h1 : 4'h7;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(done_cnt == 1, {tag, " R10 one done pulse"}, done_cnt, 1);
    check(late_bad == 0, {tag, " R10 done follows last data clock"}, late_bad, 0);
    check(ready_bad == 0, {tag, " R10 ready only when idle"}, ready_bad, 0);
    check(got_st == 2'(exp_st), {tag, " status"}, got_st, exp_st);
    check(got_cnt == 8'(exp_cnt), {tag, " count"}, got_cnt, exp_cnt);
    check(attempts == exp_att, {tag, " attempts"}, attempts, exp_att);
    check(addr_bad == 0, {tag, " R5 resume address"}, addr_bad, 0);
    if (exp_gap > 0) check(min_gap >= exp_gap, {tag, " R9 idle gap"}, min_gap, exp_gap);
    check(sts_rx_mabort == (exp_st == 1), {tag, " R2 mabort flag"}, sts_rx_mabort, exp_st == 1);
    check(sts_rx_tabort == (exp_st == 2), {tag, " R4 tabort flag"}, sts_rx_tabort, exp_st == 2);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!bus_frame && !bus_irdy, "R11 bus idle in reset", bus_frame, 0);
    check(req_ready, "R11 ready in reset", req_ready, 1);
    check(!done && !sts_rx_mabort && !sts_rx_tabort, "R11 done and flags clear", done, 0);

    // R1 R7: select delay sweep; delay 0..4 completes, 5 and above master-aborts (R2)
    for (int len = 1; len <= 6; len++)
      for (int d = 0; d <= 6; d++)
        if (d < 5) run(len, 0, d, 0, 0, -1, 1, 0, len, 1, 0, "R1 R7 normal");
        else       run(len, 0, d, 0, 0, -1, 1, 1, 0, 1, 0, "R1 R2 mabort");

    // R5: disconnect every de words
    for (int len = 1; len <= 6; len++)
      for (int de = 1; de <= 3; de++)
        run(len, 0, 1, de, 0, -1, 1, 0, len, (len + de - 1) / de, 1, "R5 disconnect");

    // R6: retries before success, gap of at least two idle clocks
    for (int n = 1; n <= 3; n++)
      for (int len = 1; len <= 3; len += 2)
        run(len, 0, 0, 0, n, -1, 1, 0, len, n + 1, 2, "R6 retry");

    // R4: target abort at every word position of a 4-word burst
    for (int w = 0; w < 4; w++)
      run(4, 0, 1, 0, 0, w, 1, 2, w, 1, 0, "R4 target abort");

    // R8: latency expiry with grant removed; words per attempt = LAT+1-delay
    for (int len = 1; len <= 12; len++)
      for (int d = 0; d <= 2; d++)
        run(len, 0, d, 0, 0, -1, 0, 0, len, (len + (LAT + 1 - d) - 1) / (LAT + 1 - d), 1,
            "R8 latency");

    // R3: special cycle, one phase only, master abort is not an error
    run(3, 1, 0, 0, 0, -1, 1, 0, 1, 1, 0, "R3 special claimed");
    run(3, 1, 99, 0, 0, -1, 1, 0, 1, 1, 0, "R3 special unclaimed");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule